// File: doc/BRIEF.md
# Configuration Port Decoder

This block sits on the host I/O bus of a bridge and turns I/O port accesses into configuration transactions. One I/O port holds a 32-bit address latch. Four further ports form a data window. Software writes a full dword to the latch to select a bus, a device/function and a register. While the enable bit of that latch is set, any access to the data window is forwarded as one configuration request. The request carries the bus number, the device/function number, a 10-bit dword register index and the byte lanes touched by the access.

The I/O side uses a byte port address, a size code, read and write strobes, lane-positioned write data, registered read data and a ready signal. A host presents an access with a one-cycle strobe while `io_ready` is high. Latch accesses, dropped window accesses and accesses to other ports finish at the accepting edge. A forwarded access lowers `io_ready` until the configuration target acknowledges it. The target can report that no device answered. A read then returns all ones on the accessed lanes.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the address latch reads 0, `io_ready` is 1 and `cfg_req` is 0.
- R2: A dword write (size code 2) to port 0xCF8 stores all 32 bits into the latch, and a dword read of 0xCF8 returns them unchanged. Writing 0x80000000 reads back as 0x80000000, and writing a saved value back restores it.
- R3: A byte write (size 0) or word write (size 1) to any of ports 0xCF8..0xCFB leaves the latch unchanged.
- R4: A byte or word read of the latch ports returns the addressed latch lanes in their lane positions and zero in the other lanes. Lane n is bits 8n+7:8n and is selected by port address bits 1:0.
- R5: When latch bit 31 is set, each accepted access to the data window (0xCFC..0xCFF) issues exactly one request. The request carries `cfg_bus` = latch bits 23:16 and `cfg_devfn` = latch bits 15:8. `cfg_reg` = {latch bits 27:24, latch bits 7:2}, so its top 4 bits are the extended register offset bits 11:8. Latch bits 1:0 are ignored.
- R6: Lane mapping: a byte at 0xCFC+n gives byte enables 1<<n. A word at 0xCFC gives 4'b0011 and a word at 0xCFE gives 4'b1100. A dword at 0xCFC gives 4'b1111. A word at an odd port, a dword at any port other than 0xCFC, and size code 3 are not forwarded, and such a read returns 0.
- R7: While latch bit 31 is clear, a data-window read is not forwarded and returns all ones on its lanes. A data-window write is dropped, and the target register keeps its value.
- R8: From the accepting edge of a forwarded access until the edge at which `cfg_ack` is seen, `io_ready` is low. Throughout that span `cfg_req` and every request field stay constant.
- R9: A forwarded read returns `cfg_rdata` masked to the accessed lanes when `cfg_present` is 1 at the acknowledge, and 0xFFFFFFFF masked to those lanes when it is 0. Unaccessed lanes read 0.
- R10: A forwarded write sets `cfg_we` and passes `io_wdata` unchanged as `cfg_wdata`. Data is lane-positioned.
- R11: An access to a port outside 0xCF8..0xCFF issues no request, changes no latch bit and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O byte port address |
| io_size | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| io_rd | input | 1 | Read strobe, one cycle, taken while io_ready is 1 |
| io_wr | input | 1 | Write strobe, one cycle, taken while io_ready is 1 |
| io_wdata | input | 32 | Lane-positioned write data |
| io_rdata | output | 32 | Registered lane-positioned read data |
| io_ready | output | 1 | High when a new access can be taken |
| cfg_req | output | 1 | Configuration request pending |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Bus number |
| cfg_devfn | output | 8 | Device (7:3) and function (2:0) |
| cfg_reg | output | 10 | Dword register index, extended bits on top |
| cfg_be | output | 4 | Byte lanes of the request |
| cfg_wdata | output | 32 | Write data |
| cfg_ack | input | 1 | Target completes the pending request |
| cfg_present | input | 1 | Target decoded the device at the acknowledge |
| cfg_rdata | input | 32 | Target read data at the acknowledge |

## Verification
Latch accesses, dropped window accesses and accesses to other ports update `io_rdata` at the edge that accepts them. The bench therefore reads it at the following falling edge with no wait. A forwarded access shows its request fields from the accepting edge. Its read data and the return of `io_ready` follow the edge at which `cfg_ack` is seen. The bench target acknowledges on its fourth edge after acceptance, so the bench expects exactly four falling edges with `io_ready` low. It reads the data at the first falling edge after that span and compares the request fields the target latched at the acknowledge.

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder #(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 'hCF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 'hCFC,
  parameter int EXT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [1:0]        io_size,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [31:0]       io_wdata,
  output logic [31:0]       io_rdata,
  output logic              io_ready,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [7:0]        cfg_bus,
  output logic [7:0]        cfg_devfn,
  output logic [EXT_W+5:0]  cfg_reg,
  output logic [3:0]        cfg_be,
  output logic [31:0]       cfg_wdata,
  input  logic              cfg_ack,
  input  logic              cfg_present,
  input  logic [31:0]       cfg_rdata
);
  localparam int RW = EXT_W + 6;

  logic [31:0] latch_q, rdata_q, lanes, be_bits, rsp_data;
  logic [3:0]  mask;
  logic        busy_q, acc, hit_latch, hit_data, latch_wr, fwd, done;

  always_comb begin
    case (io_size)
      2'd0:    mask = 4'b0001 << io_addr[1:0];
      2'd1:    mask = io_addr[0] ? 4'b0000 : (io_addr[1] ? 4'b1100 : 4'b0011);
      2'd2:    mask = (io_addr[1:0] == 2'd0) ? 4'b1111 : 4'b0000;
      default: mask = 4'b0000;
    endcase
  end

  assign lanes     = {{8{mask[3]}}, {8{mask[2]}}, {8{mask[1]}}, {8{mask[0]}}};
  assign be_bits   = {{8{cfg_be[3]}}, {8{cfg_be[2]}}, {8{cfg_be[1]}}, {8{cfg_be[0]}}};
  assign acc       = !busy_q && (io_rd || io_wr);
  assign hit_latch = io_addr[IO_AW-1:2] == ADDR_PORT[IO_AW-1:2];
  assign hit_data  = io_addr[IO_AW-1:2] == DATA_PORT[IO_AW-1:2];
  assign latch_wr  = acc && io_wr && io_addr == ADDR_PORT && io_size == 2'd2;
  assign fwd       = acc && hit_data && mask != 4'b0000 && latch_q[31];
  assign done      = cfg_req && cfg_ack;
  assign rsp_data  = (cfg_present ? cfg_rdata : 32'hFFFF_FFFF) & be_bits;

  assign io_ready  = !busy_q;
  assign io_rdata  = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q   <= '0;
      rdata_q   <= '0;
      busy_q    <= 1'b0;
      cfg_req   <= 1'b0;
      cfg_we    <= 1'b0;
      cfg_bus   <= '0;
      cfg_devfn <= '0;
      cfg_reg   <= '0;
      cfg_be    <= '0;
      cfg_wdata <= '0;
    end else begin
      if (latch_wr) latch_q <= io_wdata;
      if (fwd) begin
        busy_q    <= 1'b1;
        cfg_req   <= 1'b1;
        cfg_we    <= io_wr;
        cfg_bus   <= latch_q[23:16];
        cfg_devfn <= latch_q[15:8];
        cfg_reg   <= {latch_q[24+EXT_W-1:24], latch_q[7:2]};
        cfg_be    <= mask;
        cfg_wdata <= io_wdata;
      end else if (acc && !io_wr) begin
        if (hit_latch)     rdata_q <= latch_q & lanes;
        else if (hit_data) rdata_q <= lanes;
        else               rdata_q <= '0;
      end
      if (done) begin
        busy_q  <= 1'b0;
        cfg_req <= 1'b0;
        if (!cfg_we) rdata_q <= rsp_data;
      end
    end
  end

  AST_LATCH_WR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latch_q) |-> $past(io_wr && io_ready && io_addr == ADDR_PORT && io_size == 2'd2)); // R3
  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req) |-> $past(latch_q[31])); // R7
  AST_REQ_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req) |-> cfg_bus == $past(latch_q[23:16]) && cfg_devfn == $past(latch_q[15:8])); // R5
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_ack |=> !cfg_req && io_ready); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> cfg_req && !io_ready && $stable(cfg_reg) && $stable(cfg_be)
                            && $stable(cfg_wdata) && $stable(cfg_we)); // R8
  AST_BE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> ($countones(cfg_be) == 1 || cfg_be == 4'b0011 || cfg_be == 4'b1100 || cfg_be == 4'b1111)); // R6
  AST_RST_IDLE: assert property (@(posedge clk)
    !rst_n |=> !cfg_req && io_ready && latch_q == 32'd0); // R1
  AST_RD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_ack && !cfg_we |=> (io_rdata & ~$past(be_bits)) == 32'd0); // R9
endmodule

// File: tb/tb_cfg_port_decoder.sv
module tb_cfg_port_decoder;
  logic clk = 0, rst_n = 0;
  logic [15:0] io_addr = 0;
  logic [1:0]  io_size = 0;
  logic io_rd = 0, io_wr = 0;
  logic [31:0] io_wdata = 0, io_rdata;
  logic io_ready, cfg_req, cfg_we;
  logic [7:0] cfg_bus, cfg_devfn;
  logic [9:0] cfg_reg;
  logic [3:0] cfg_be;
  logic [31:0] cfg_wdata;
  logic tack = 0, tfound = 0;
  logic [31:0] trdata = 0;

  int checks = 0, fails = 0, nreq = 0, twait = 0;
  logic [7:0] r_bus, r_devfn;
  logic [9:0] r_reg;
  logic [3:0] r_be;
  logic [31:0] r_wd;
  logic r_we;
  logic [31:0] tmem [512];
  logic [31:0] emem [512];

  always #2.5 clk = ~clk;

  cfg_port_decoder dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_size(io_size), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ready(io_ready), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn), .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_ack(tack), .cfg_present(tfound), .cfg_rdata(trdata));

  function automatic logic [8:0] key(input logic [7:0] b, input logic [7:0] df, input logic [9:0] r);
    return {b[0], df[3:0], r[9], r[2:0]};
  endfunction
  function automatic logic [31:0] seed(input int i);
    return (i * 32'h0101_0101) ^ 32'hA55A_3C00;
  endfunction
  function automatic logic [31:0] ln(input logic [3:0] m);
    return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
  endfunction
  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] m);
    return (old & ~ln(m)) | (nw & ln(m));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      tack <= 0; twait <= 0;
      for (int i = 0; i < 512; i++) tmem[i] <= seed(i);
    end else if (cfg_req && !tack) begin
      if (twait == 2) begin
        tack <= 1; twait <= 0; nreq <= nreq + 1;
        r_bus <= cfg_bus; r_devfn <= cfg_devfn; r_reg <= cfg_reg;
        r_be <= cfg_be; r_wd <= cfg_wdata; r_we <= cfg_we;
        tfound <= cfg_devfn[7:3] < 2;
        trdata <= tmem[key(cfg_bus, cfg_devfn, cfg_reg)];
        if (cfg_we && cfg_devfn[7:3] < 2)
          tmem[key(cfg_bus, cfg_devfn, cfg_reg)] <=
            merge(tmem[key(cfg_bus, cfg_devfn, cfg_reg)], cfg_wdata, cfg_be);
      end else twait <= twait + 1;
    end else begin
      tack <= 0; twait <= 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [15:0] a, input logic [1:0] sz, input bit wr, input logic [31:0] wd,
                     output logic [31:0] rd, output int busy);
    @(negedge clk);
    io_addr = a; io_size = sz; io_wr = wr; io_rd = !wr; io_wdata = wd;
    @(negedge clk);
    io_rd = 0; io_wr = 0; busy = 0;
    while (!io_ready && busy < 50) begin busy++; @(negedge clk); end
    rd = io_rdata;
  endtask

  logic [31:0] rd, lat;
  int bsy, n0;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) emem[i] = seed(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", {31'd0, io_ready}, 32'd1);
    chk("R1 req", {31'd0, cfg_req}, 32'd0);
    acc(16'hCF8, 2, 0, 0, rd, bsy);
    chk("R1 latch", rd, 32'd0);

    acc(16'hCF8, 2, 1, 32'h8000_0000, rd, bsy);
    acc(16'hCF8, 2, 0, 0, rd, bsy);
    chk("R2 enable readback", rd, 32'h8000_0000);
    acc(16'hCF8, 2, 1, 32'h7ABC_DE13, rd, bsy);
    acc(16'hCF8, 2, 0, 0, rd, bsy);
    chk("R2 full word", rd, 32'h7ABC_DE13);

    acc(16'hCFB, 0, 1, 32'h0100_0000, rd, bsy);
    acc(16'hCF8, 2, 0, 0, rd, bsy);
    chk("R3 byte to CFB", rd, 32'h7ABC_DE13);
    acc(16'hCF8, 1, 1, 32'h0000_FFFF, rd, bsy);
    acc(16'hCFA, 1, 1, 32'hFFFF_0000, rd, bsy);
    acc(16'hCF8, 2, 0, 0, rd, bsy);
    chk("R3 word writes", rd, 32'h7ABC_DE13);
    acc(16'hCF8, 2, 1, 32'h8000_0000, rd, bsy);
    acc(16'hCF8, 2, 1, 32'h7ABC_DE13, rd, bsy);
    acc(16'hCF8, 2, 0, 0, rd, bsy);
    chk("R2 restore", rd, 32'h7ABC_DE13);

    lat = 32'h80A1_B2C7;
    acc(16'hCF8, 2, 1, lat, rd, bsy);
    for (int n = 0; n < 4; n++) begin
      acc(16'hCF8 + 16'(n), 0, 0, 0, rd, bsy);
      chk("R4 byte lane", rd, lat & ln(4'b0001 << n));
    end
    acc(16'hCFA, 1, 0, 0, rd, bsy);
    chk("R4 upper word", rd, 32'h80A1_0000);

    n0 = nreq;
    acc(16'h0080, 2, 0, 0, rd, bsy);
    chk("R11 other port read", rd, 32'd0);
    acc(16'h0CF4, 2, 1, 32'hFFFF_FFFF, rd, bsy);
    acc(16'hCF8, 2, 0, 0, rd, bsy);
    chk("R11 latch untouched", rd, lat);
    chk("R11 no request", nreq, n0);

    acc(16'hCF8, 2, 1, 32'h8000_0000, rd, bsy);
    n0 = nreq;
    acc(16'hCFD, 1, 0, 0, rd, bsy);
    chk("R6 odd word read", rd, 32'd0);
    acc(16'hCFE, 2, 0, 0, rd, bsy);
    chk("R6 dword not at CFC", rd, 32'd0);
    acc(16'hCFC, 3, 0, 0, rd, bsy);
    chk("R6 reserved size", rd, 32'd0);
    chk("R6 none forwarded", nreq, n0);

    acc(16'hCF8, 2, 1, 32'h0000_0114, rd, bsy);
    n0 = nreq;
    acc(16'hCFC, 2, 0, 0, rd, bsy);
    chk("R7 disabled read", rd, 32'hFFFF_FFFF);
    acc(16'hCFE, 0, 0, 0, rd, bsy);
    chk("R7 disabled byte read", rd, 32'h00FF_0000);
    acc(16'hCFC, 2, 1, 32'h1234_5678, rd, bsy);
    chk("R7 no request", nreq, n0);
    chk("R7 no stall", bsy, 0);
    acc(16'hCF8, 2, 1, 32'h8000_0114, rd, bsy);
    acc(16'hCFC, 2, 0, 0, rd, bsy);
    chk("R7 write dropped", rd, emem[key(8'h00, 8'h01, 10'h005)]);

    foreach (emem[i]) ;
    for (int bi = 0; bi < 2; bi++)
      for (int dv = 0; dv < 4; dv++)
        for (int fi = 0; fi < 3; fi++)
          for (int ri = 0; ri < 3; ri++) begin
            logic [7:0] b, df; logic [9:0] r; logic [8:0] k; bit fnd; logic [31:0] wd, ex;
            b  = bi ? 8'hC5 : 8'h00;
            df = {(dv == 3) ? 5'd31 : 5'(dv), (fi == 0) ? 3'd0 : (fi == 1) ? 3'd3 : 3'd7};
            r  = (ri == 0) ? 10'h000 : (ri == 1) ? 10'h3FF : 10'h041;
            k  = key(b, df, r);
            fnd = df[7:3] < 2;
            acc(16'hCF8, 2, 1, {1'b1, 3'b000, r[9:6], b, df, r[5:0], 2'b01}, rd, bsy);
            n0 = nreq;
            acc(16'hCFC, 2, 0, 0, rd, bsy);
            chk("R9 dword read", rd, fnd ? emem[k] : 32'hFFFF_FFFF);
            chk("R5 one request", nreq, n0 + 1);
            chk("R5 bus", {24'd0, r_bus}, {24'd0, b});
            chk("R5 devfn", {24'd0, r_devfn}, {24'd0, df});
            chk("R5 reg index", {22'd0, r_reg}, {22'd0, r});
            chk("R6 dword lanes", {28'd0, r_be}, 32'hF);
            chk("R8 busy span", bsy, 4);
            for (int n = 0; n < 4; n++) begin
              wd = 32'((b + df * 3 + r + n * 17) & 8'hFF) << (8 * n);
              acc(16'hCFC + 16'(n), 0, 1, wd, rd, bsy);
              chk("R6 byte lanes", {28'd0, r_be}, 32'(4'b0001 << n));
              chk("R10 write data", r_wd, wd);
              chk("R10 write flag", {31'd0, r_we}, 32'd1);
              if (fnd) emem[k] = merge(emem[k], wd, 4'b0001 << n);
            end
            wd = 32'h5A00_0000 | (32'(r) << 16);
            acc(16'hCFE, 1, 1, wd, rd, bsy);
            chk("R6 upper word lanes", {28'd0, r_be}, 32'hC);
            if (fnd) emem[k] = merge(emem[k], wd, 4'b1100);
            ex = fnd ? emem[k] : 32'hFFFF_FFFF;
            for (int n = 0; n < 4; n++) begin
              acc(16'hCFC + 16'(n), 0, 0, 0, rd, bsy);
              chk("R9 byte read", rd, ex & ln(4'b0001 << n));
            end
            acc(16'hCFC, 1, 0, 0, rd, bsy);
            chk("R9 low word read", rd, ex & 32'h0000_FFFF);
            chk("R6 low word lanes", {28'd0, r_be}, 32'h3);
          end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule